// File: doc/BRIEF.md
# Register-Pair Load/Store Sequencer

This unit executes 64-bit loads and stores on a 32-bit integer core where the 64-bit datum occupies an even/odd register pair. It accepts one decoded operation at a time: a load/store flag, the base register value and index, a 12-bit signed offset, the even data register index and, for stores, the two words read from the pair. It forms the effective address, rejects odd data indices and addresses that are not word-aligned, and otherwise performs the transfer as two 32-bit word accesses on a single-outstanding request/response memory port, low word first.

Loaded words go back through one 32-bit register write port. The word headed for the even register lands in the cycle its response arrives. The same holds for the word headed for the odd register, unless that register is the one the address was computed from. In that case the word is parked in a holding register. It is committed only after both accesses have succeeded, so a faulting second access never destroys the base value. One cycle after the final response, a single `done` pulse carries the trap cause and the faulting address.

Top module: `pair_lsu`

## Requirements
- R1: The effective address is `base_val` plus the sign-extended 12-bit `imm`. A legal operation makes exactly two word accesses, the first at the effective address and the second at the effective address plus 4.
- R2: An odd `data_idx` raises trap cause 2 (illegal), with `trap_addr` equal to the effective address. No memory request is made and `done` is high in the cycle after acceptance. This check takes priority over the alignment check.
- R3: An effective address whose two low bits are not both zero raises trap cause 1 (misaligned), with `trap_addr` equal to the effective address and no memory request. Addresses that are a multiple of 4, including multiples of 8, never raise cause 1.
- R4: On a load, the word read from the effective address goes to register `data_idx`, and the word read from the address plus 4 goes to register `data_idx`+1.
- R5: A loaded word whose target register is not `base_idx` is written with `rf_we` in the same cycle as its memory response.
- R6: A loaded word whose target register equals `base_idx` is written in the cycle `done` is high, and only if no trap occurred. When a trap occurs, the base register is never written.
- R7: A response with `mem_rsp_err` set raises trap cause 3 (access fault), with `trap_addr` equal to that word's address. A fault on the first word suppresses the second access.
- R8: A load with `data_idx` equal to 0 still makes both accesses, but asserts `rf_we` for neither register 0 nor register 1.
- R9: A store drives `mem_we` high on both accesses, with `st_lo` at the effective address and `st_hi` at the address plus 4. When `data_idx` is 0, both words are written as zero, whatever the store inputs carry.
- R10: `done` is high for one cycle, exactly one cycle after the final memory response (or after acceptance when the operation traps early). While `busy` is high, `op_valid` is ignored.
- R11: After reset, `busy`, `mem_req`, `rf_we` and `done` are low and `trap_cause` is 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered; taken when `busy` is low |
| op_store | input | 1 | 1 = store, 0 = load |
| base_val | input | 32 | Base register value |
| imm | input | 12 | Signed address offset |
| base_idx | input | 5 | Base register index |
| data_idx | input | 5 | Data pair index (must be even) |
| st_lo | input | 32 | Store word for the even register |
| st_hi | input | 32 | Store word for the odd register |
| busy | output | 1 | Operation in flight |
| mem_req | output | 1 | Word access request, held until response |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the current request |
| mem_rsp_err | input | 1 | Response reports an access fault |
| mem_rdata | input | 32 | Read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| done | output | 1 | Operation finished, one-cycle pulse |
| trap_cause | output | 2 | 0 none, 1 misaligned, 2 illegal, 3 access fault |
| trap_addr | output | 32 | Address tied to the trap |

## Verification
Loads are tried with the base register outside the pair, equal to the even register and equal to the odd register. Comparing the write cycles of these cases separates immediate writeback from held writeback. Faults are injected on the first word and on the second word: the first case shows that the second access is suppressed, and the second shows that a held base word is dropped while the other word stays written. Addresses cover multiples of 8, multiples of 4 only, a negative offset and a byte offset, which checks the sign extension and the alignment classes. Store sources cover a normal pair and register 0 with non-zero store inputs, and an odd index combined with a misaligned address checks which trap takes priority.

// File: rtl/pair_lsu_pkg.sv
package pair_lsu_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int IMM_W  = 12;
    localparam int IDX_W  = 5;
    localparam int WORD_BYTES = WORD_W / 8;

    typedef enum logic [1:0] {
        TRAP_NONE     = 2'd0,
        TRAP_MISALIGN = 2'd1,
        TRAP_ILLEGAL  = 2'd2,
        TRAP_FAULT    = 2'd3
    } trap_e;

    typedef enum logic [1:0] {
        ALIGN_DWORD = 2'd0,
        ALIGN_WORD  = 2'd1,
        ALIGN_NONE  = 2'd2
    } align_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_FIN  = 2'd3
    } state_e;

    // Memory-side view of an accepted operation
    typedef struct packed {
        logic              is_store;
        logic [ADDR_W-1:0] ea;
        logic [WORD_W-1:0] wlo;
        logic [WORD_W-1:0] whi;
    } mem_op_t;

    // Writeback-side view of an accepted operation
    typedef struct packed {
        logic [IDX_W-1:0] lo_idx;
        logic [IDX_W-1:0] hi_idx;
        logic             lo_is_base;
        logic             hi_is_base;
        logic             discard;
    } wb_ctx_t;

    function automatic logic [ADDR_W-1:0] calc_ea(
        input logic [ADDR_W-1:0] base,
        input logic [IMM_W-1:0]  ofs
    );
        return base + {{(ADDR_W-IMM_W){ofs[IMM_W-1]}}, ofs};
    endfunction

    function automatic align_e classify(input logic [ADDR_W-1:0] a);
        if (a[2:0] == 3'b000)      return ALIGN_DWORD;
        else if (a[1:0] == 2'b00)  return ALIGN_WORD;
        else                       return ALIGN_NONE;
    endfunction

endpackage

// File: rtl/pair_lsu_agen.sv
module pair_lsu_agen
    import pair_lsu_pkg::*;
(
    input  logic              is_store,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [IDX_W-1:0]  data_idx,
    input  logic [WORD_W-1:0] st_lo,
    input  logic [WORD_W-1:0] st_hi,
    output mem_op_t           mem_op,
    output wb_ctx_t           wb_ctx,
    output trap_e             early_trap
);

    logic   src_zero;
    align_e aln;

    always_comb begin
        src_zero = (data_idx == '0);
        aln      = classify(calc_ea(base_val, imm));

        mem_op.is_store = is_store;
        mem_op.ea       = calc_ea(base_val, imm);
        mem_op.wlo      = (is_store && !src_zero) ? st_lo : '0;
        mem_op.whi      = (is_store && !src_zero) ? st_hi : '0;

        wb_ctx.lo_idx     = {data_idx[IDX_W-1:1], 1'b0};
        wb_ctx.hi_idx     = {data_idx[IDX_W-1:1], 1'b1};
        wb_ctx.lo_is_base = (base_idx == {data_idx[IDX_W-1:1], 1'b0});
        wb_ctx.hi_is_base = (base_idx == {data_idx[IDX_W-1:1], 1'b1});
        wb_ctx.discard    = is_store || src_zero;

        // Reserved register encoding is decoded before the address is judged
        if (data_idx[0])
            early_trap = TRAP_ILLEGAL;
        else if (aln == ALIGN_NONE)
            early_trap = TRAP_MISALIGN;
        else
            early_trap = TRAP_NONE;
    end

endmodule

// File: rtl/pair_lsu_ctrl.sv
module pair_lsu_ctrl
    import pair_lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  mem_op_t           dec_op,
    input  trap_e             early_trap,
    output logic              accept,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    output logic              word_ok,
    output logic              word_hi,
    output logic              finish,
    output trap_e             trap,
    output logic [ADDR_W-1:0] trap_addr
);

    state_e            state_q;
    mem_op_t           op_q;
    trap_e             trap_q;
    logic [ADDR_W-1:0] taddr_q;
    logic [ADDR_W-1:0] hi_addr;
    logic              rsp_fire;

    assign hi_addr  = op_q.ea + ADDR_W'(WORD_BYTES);
    assign busy     = (state_q != ST_IDLE);
    assign accept   = (state_q == ST_IDLE) && op_valid;
    assign mem_req  = (state_q == ST_LO) || (state_q == ST_HI);
    assign mem_we   = mem_req && op_q.is_store;
    assign mem_addr = (state_q == ST_HI) ? hi_addr : op_q.ea;
    assign mem_wdata = (state_q == ST_HI) ? op_q.whi : op_q.wlo;
    assign rsp_fire = mem_req && mem_rsp_valid;
    assign word_ok  = rsp_fire && !mem_rsp_err && !op_q.is_store;
    assign word_hi  = (state_q == ST_HI);
    assign finish   = (state_q == ST_FIN);
    assign trap     = trap_q;
    assign trap_addr = taddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            trap_q  <= TRAP_NONE;
            taddr_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (op_valid) begin
                        op_q    <= dec_op;
                        trap_q  <= early_trap;
                        taddr_q <= dec_op.ea;
                        state_q <= (early_trap != TRAP_NONE) ? ST_FIN : ST_LO;
                    end
                end
                ST_LO: begin
                    if (rsp_fire) begin
                        if (mem_rsp_err) begin
                            trap_q  <= TRAP_FAULT;
                            taddr_q <= op_q.ea;
                            state_q <= ST_FIN;
                        end else begin
                            state_q <= ST_HI;
                        end
                    end
                end
                ST_HI: begin
                    if (rsp_fire) begin
                        if (mem_rsp_err) begin
                            trap_q  <= TRAP_FAULT;
                            taddr_q <= hi_addr;
                        end
                        state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pair_lsu_wb.sv
module pair_lsu_wb
    import pair_lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  wb_ctx_t           dec_ctx,
    input  logic              word_ok,
    input  logic              word_hi,
    input  logic [WORD_W-1:0] rdata,
    input  logic              finish,
    input  trap_e             trap,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [WORD_W-1:0] rf_wdata
);

    wb_ctx_t           ctx_q;
    logic              hold_v;
    logic [IDX_W-1:0]  hold_idx;
    logic [WORD_W-1:0] hold_data;
    logic [IDX_W-1:0]  tgt_idx;
    logic              tgt_base;
    logic              direct;
    logic              park;
    logic              commit;

    assign tgt_idx  = word_hi ? ctx_q.hi_idx     : ctx_q.lo_idx;
    assign tgt_base = word_hi ? ctx_q.hi_is_base : ctx_q.lo_is_base;
    assign direct   = word_ok && !ctx_q.discard && !tgt_base;
    assign park     = word_ok && !ctx_q.discard &&  tgt_base;
    assign commit   = finish && hold_v && (trap == TRAP_NONE);

    assign rf_we    = direct || commit;
    assign rf_waddr = direct ? tgt_idx : hold_idx;
    assign rf_wdata = direct ? rdata   : hold_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q     <= '0;
            hold_v    <= 1'b0;
            hold_idx  <= '0;
            hold_data <= '0;
        end else begin
            if (accept)
                ctx_q <= dec_ctx;
            if (park) begin
                hold_v    <= 1'b1;
                hold_idx  <= tgt_idx;
                hold_data <= rdata;
            end else if (finish) begin
                hold_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pair_lsu.sv
module pair_lsu
    import pair_lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_store,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [IDX_W-1:0]  data_idx,
    input  logic [WORD_W-1:0] st_lo,
    input  logic [WORD_W-1:0] st_hi,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic              done,
    output logic [1:0]        trap_cause,
    output logic [ADDR_W-1:0] trap_addr
);

    mem_op_t dec_op;
    wb_ctx_t dec_ctx;
    trap_e   early_trap;
    logic    accept;
    logic    word_ok;
    logic    word_hi;
    logic    finish;
    trap_e   trap;

    pair_lsu_agen u_agen (
        .is_store   (op_store),
        .base_val   (base_val),
        .imm        (imm),
        .base_idx   (base_idx),
        .data_idx   (data_idx),
        .st_lo      (st_lo),
        .st_hi      (st_hi),
        .mem_op     (dec_op),
        .wb_ctx     (dec_ctx),
        .early_trap (early_trap)
    );

    pair_lsu_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .op_valid      (op_valid),
        .dec_op        (dec_op),
        .early_trap    (early_trap),
        .accept        (accept),
        .busy          (busy),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .word_ok       (word_ok),
        .word_hi       (word_hi),
        .finish        (finish),
        .trap          (trap),
        .trap_addr     (trap_addr)
    );

    pair_lsu_wb u_wb (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .dec_ctx  (dec_ctx),
        .word_ok  (word_ok),
        .word_hi  (word_hi),
        .rdata    (mem_rdata),
        .finish   (finish),
        .trap     (trap),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata)
    );

    assign done       = finish;
    assign trap_cause = finish ? trap : TRAP_NONE;

endmodule

// File: rtl/pair_lsu_chk.sv
module pair_lsu_chk
    import pair_lsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [IDX_W-1:0]  data_idx,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rsp_valid,
    input logic              rf_we,
    input logic [IDX_W-1:0]  rf_waddr,
    input logic              done,
    input logic [1:0]        trap_cause
);

    assert_illegal_no_access_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && data_idx[0]) |=> (done && trap_cause == 2'd2 && !mem_req));

    assert_word_aligned_req_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_no_write_on_trap_R6: assert property (@(posedge clk) disable iff (rst)
        (done && trap_cause != 2'd0) |-> !rf_we);

    assert_no_low_pair_write_R8: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr[IDX_W-1:1] != '0));

    assert_done_follows_event_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_req && mem_rsp_valid) || $past(op_valid && !busy)));

    assert_req_within_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req || done) |-> busy);

endmodule

bind pair_lsu pair_lsu_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_valid      (op_valid),
    .data_idx      (data_idx),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr),
    .done          (done),
    .trap_cause    (trap_cause)
);

// File: tb/sim_pair_lsu.sv
module sim_pair_lsu;
    import pair_lsu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] NOF = 32'hFFFF_FFFF;

    typedef struct packed {
        logic        st;
        logic [31:0] base;
        logic [11:0] imm;
        logic [4:0]  bidx;
        logic [4:0]  didx;
        logic [31:0] slo;
        logic [31:0] shi;
        logic [31:0] flt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_1000, 12'h010, 5'd5,  5'd10, 32'h0, 32'h0, NOF},
        '{1'b0, 32'h0000_2000, 12'hFF8, 5'd12, 5'd12, 32'h0, 32'h0, NOF},
        '{1'b0, 32'h0000_3004, 12'h000, 5'd7,  5'd6,  32'h0, 32'h0, NOF},
        '{1'b0, 32'h0000_4000, 12'h002, 5'd1,  5'd4,  32'h0, 32'h0, NOF},
        '{1'b0, 32'h0000_4000, 12'h000, 5'd1,  5'd9,  32'h0, 32'h0, NOF},
        '{1'b0, 32'h0000_5000, 12'h000, 5'd4,  5'd4,  32'h0, 32'h0, 32'h0000_5004},
        '{1'b0, 32'h0000_6000, 12'h008, 5'd1,  5'd2,  32'h0, 32'h0, 32'h0000_6008},
        '{1'b0, 32'h0000_6100, 12'h7FC, 5'd3,  5'd0,  32'h0, 32'h0, NOF},
        '{1'b1, 32'h0000_7000, 12'h004, 5'd1,  5'd8,  32'h1111_2222, 32'h3333_4444, NOF},
        '{1'b1, 32'h0000_7000, 12'h010, 5'd1,  5'd0,  32'hDEAD_0001, 32'hBEEF_0002, NOF},
        '{1'b1, 32'h0000_7001, 12'h000, 5'd1,  5'd3,  32'h5, 32'h6, NOF},
        '{1'b1, 32'h0000_7100, 12'h000, 5'd2,  5'd6,  32'hAAAA_0000, 32'hBBBB_0000, 32'h0000_7104},
        '{1'b0, 32'h0000_9000, 12'h000, 5'd9,  5'd8,  32'h0, 32'h0, 32'h0000_9004}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_store = 1'b0;
    logic [31:0] base_val = '0;
    logic [11:0] imm = '0;
    logic [4:0]  base_idx = '0;
    logic [4:0]  data_idx = '0;
    logic [31:0] st_lo = '0;
    logic [31:0] st_hi = '0;
    logic [31:0] fault_addr = NOF;
    logic        busy, mem_req, mem_we, mem_rsp_valid, mem_rsp_err, rf_we, done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_wdata, trap_addr;
    logic [4:0]  rf_waddr;
    logic [1:0]  trap_cause;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    // Memory answers every request in the cycle it is raised
    assign mem_rsp_valid = mem_req;
    assign mem_rsp_err   = mem_req && (mem_addr == fault_addr);
    assign mem_rdata     = memfn(mem_addr);

    pair_lsu u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_store(op_store),
        .base_val(base_val), .imm(imm), .base_idx(base_idx), .data_idx(data_idx),
        .st_lo(st_lo), .st_hi(st_hi), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .done(done), .trap_cause(trap_cause),
        .trap_addr(trap_addr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Observation buffers
    logic [31:0] acc_addr [4];
    logic        acc_we   [4];
    logic [31:0] acc_wd   [4];
    logic [4:0]  wr_addr  [4];
    logic [31:0] wr_data  [4];
    int          wr_cyc   [4];
    int n_acc, n_wr, done_cyc, n_done;
    logic [1:0]  got_cause;
    logic [31:0] got_taddr;

    task automatic sample(input int c);
        if (mem_req && mem_rsp_valid && n_acc < 4) begin
            acc_addr[n_acc] = mem_addr; acc_we[n_acc] = mem_we;
            acc_wd[n_acc] = mem_wdata; n_acc++;
        end
        if (rf_we && n_wr < 4) begin
            wr_addr[n_wr] = rf_waddr; wr_data[n_wr] = rf_wdata;
            wr_cyc[n_wr] = c; n_wr++;
        end
        if (done) begin
            n_done++;
            if (done_cyc == 0) begin
                done_cyc = c; got_cause = trap_cause; got_taddr = trap_addr;
            end
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] ea;
        logic [1:0]  ecause;
        int          nacc;
        logic [31:0] etaddr;
        logic [4:0]  lo, hi;
        logic [4:0]  ew_addr [4];
        logic [31:0] ew_data [4];
        int          ew_cyc  [4];
        int          ne;
        @(negedge clk);
        op_store = v.st; base_val = v.base; imm = v.imm; base_idx = v.bidx;
        data_idx = v.didx; st_lo = v.slo; st_hi = v.shi; fault_addr = v.flt;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        n_acc = 0; n_wr = 0; done_cyc = 0; n_done = 0;
        got_cause = '0; got_taddr = '0;
        for (int c = 1; c <= 6 && done_cyc == 0; c++) begin
            if (c > 1) @(negedge clk);
            sample(c);
        end

        // Expected values from the requirements
        ea = v.base + {{20{v.imm[11]}}, v.imm};
        etaddr = ea;
        nacc = 0;
        if (v.didx[0]) ecause = 2'd2;
        else if (ea[1:0] != 2'b00) ecause = 2'd1;
        else if (ea == v.flt) begin ecause = 2'd3; nacc = 1; end
        else if (ea + 32'd4 == v.flt) begin ecause = 2'd3; nacc = 2; etaddr = ea + 32'd4; end
        else begin ecause = 2'd0; nacc = 2; end

        chk("R2/R3/R7", "trap cause", {30'd0, got_cause}, {30'd0, ecause});
        if (ecause != 2'd0) chk("R7", "trap address", got_taddr, etaddr);
        chk("R10", "done cycle", done_cyc, nacc + 1);
        chk("R1", "access count", n_acc, nacc);
        for (int i = 0; i < nacc && i < n_acc; i++) begin
            chk("R1", "access address", acc_addr[i], ea + 32'(4 * i));
            chk("R9", "write strobe", {31'd0, acc_we[i]}, {31'd0, v.st});
            if (v.st)
                chk("R9", "store data", acc_wd[i],
                    (v.didx == 5'd0) ? 32'd0 : ((i == 0) ? v.slo : v.shi));
        end

        ne = 0;
        lo = v.didx; hi = v.didx | 5'd1;
        if (!v.st && v.didx != 5'd0 && (ecause == 2'd0 || ecause == 2'd3)) begin
            if (nacc >= 1 && !(ecause == 2'd3 && nacc == 1) && v.bidx != lo) begin
                ew_addr[ne] = lo; ew_data[ne] = memfn(ea); ew_cyc[ne] = 1; ne++;
            end
            if (ecause == 2'd0 && v.bidx != hi) begin
                ew_addr[ne] = hi; ew_data[ne] = memfn(ea + 32'd4); ew_cyc[ne] = 2; ne++;
            end
            if (ecause == 2'd0 && v.bidx == lo) begin
                ew_addr[ne] = lo; ew_data[ne] = memfn(ea); ew_cyc[ne] = 3; ne++;
            end
            if (ecause == 2'd0 && v.bidx == hi) begin
                ew_addr[ne] = hi; ew_data[ne] = memfn(ea + 32'd4); ew_cyc[ne] = 3; ne++;
            end
        end
        chk("R6", "register write count", n_wr, ne);
        for (int i = 0; i < ne && i < n_wr; i++) begin
            chk("R4", "write index", {27'd0, wr_addr[i]}, {27'd0, ew_addr[i]});
            chk("R4", "write data", wr_data[i], ew_data[i]);
            chk("R5", "write cycle", wr_cyc[i], ew_cyc[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: idle outputs after reset
        chk("R11", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R11", "mem_req after reset", {31'd0, mem_req}, 32'd0);
        chk("R11", "rf_we after reset", {31'd0, rf_we}, 32'd0);
        chk("R11", "done after reset", {31'd0, done}, 32'd0);
        chk("R11", "cause after reset", {30'd0, trap_cause}, 32'd0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R10: offers made while busy are ignored
        @(negedge clk);
        op_store = 1'b0; base_val = 32'h0000_8000; imm = 12'h0; base_idx = 5'd9;
        data_idx = 5'd2; fault_addr = NOF; op_valid = 1'b1;
        @(negedge clk);
        data_idx = 5'd3; base_val = 32'h0000_8001;
        n_acc = 0; n_wr = 0; done_cyc = 0; n_done = 0;
        got_cause = '0; got_taddr = '0;
        for (int c = 1; c <= 6; c++) begin
            if (c > 1) @(negedge clk);
            if (c == 3) op_valid = 1'b0;
            sample(c);
        end
        chk("R10", "done pulses while busy", n_done, 1);
        chk("R10", "done cycle while busy", done_cyc, 3);
        chk("R10", "cause after ignored offer", {30'd0, got_cause}, 32'd0);
        chk("R10", "access count", n_acc, 2);
        chk("R10", "idle afterwards", {31'd0, busy}, 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule